// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block holds the interrupt state of one processor for 256 vectors. It keeps three vector bitmaps: requests waiting for delivery, vectors currently being serviced, and the trigger mode (edge or level) of each request. A task-priority register sets a floor, and from it and the highest in-service vector the block derives a processor priority. The block compares the highest waiting request against that priority and presents it when its priority class is higher. Priority classes use the upper four bits of an 8-bit vector.

Software or a routing fabric hands in requests on the accept port. The core takes the presented vector with an acknowledge strobe. An end-of-interrupt strobe retires the highest in-service vector. One cycle later the block reports the retired vector and whether it was level-triggered, so that a level source can be re-armed. Address decoding, destination selection and timers sit outside this block.

Top module: `vec_prio_tracker`

## Requirements
- R1: After reset all three bitmaps and the task priority are zero, so `irq_valid` = 0, `ppr` = 0 and `eoi_valid` = 0.
- R2: An accept request (`acc_valid` = 1) is taken, with `acc_taken` = 1 in the same cycle, when `ctl_enable` = 1 and the vector is not already pending. From the next cycle the vector is pending.
- R3: An accept request for a vector that is already pending gives `acc_taken` = 0 and leaves the pending set and the stored trigger mode unchanged.
- R4: While `ctl_enable` = 0, every accept request gives `acc_taken` = 0 and nothing becomes pending.
- R5: The request considered for delivery is the highest-numbered pending vector. Vector v is held in 32-bit word v>>5 at bit v&31, and the words are searched from the top word down.
- R6: `ppr` equals the stored task priority when the task priority's bits [7:4] are at least bits [7:4] of the highest in-service vector. Otherwise `ppr` equals that vector with bits [3:0] cleared. An empty in-service set counts as vector 0.
- R7: `irq_valid` = 1 only when a vector is pending and bits [7:4] of the highest pending vector are strictly greater than bits [7:4] of `ppr`. `irq_vector` then carries that vector.
- R8: `ack` while `irq_valid` = 1 moves `irq_vector` from pending to in-service at the clock edge. `ack` while `irq_valid` = 0 changes nothing.
- R9: `eoi` while a vector is in service clears the highest in-service vector and clears its trigger bit. In the next cycle `eoi_valid` = 1, `eoi_vector` carries the retired vector, and `eoi_level` = 1 if its trigger bit was set (level) or 0 if it was clear (edge).
- R10: `eoi` with an empty in-service set gives `eoi_valid` = 0 in the next cycle and leaves `ppr` unchanged.
- R11: A task-priority write (`tpr_wr` = 1) stores only bits [7:0] of `tpr_wdata`.
- R12: Operations issued in the same cycle all act on the state as it stood before the clock edge. When an accept and an EOI touch the trigger bit of the same vector, the EOI reports the old bit and the accepted request's trigger mode is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | 1 | Controller enable; accept requests are dropped when 0 |
| acc_valid | input | 1 | Accept request strobe |
| acc_vector | input | 8 | Vector to make pending |
| acc_level | input | 1 | Trigger mode of the request: 1 level, 0 edge |
| acc_taken | output | 1 | The request in this cycle is accepted |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data; only bits [7:0] are kept |
| ack | input | 1 | Acknowledge of the presented vector |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_valid | output | 1 | A deliverable vector is presented |
| irq_vector | output | 8 | Presented vector |
| ppr | output | 8 | Current processor priority |
| eoi_valid | output | 1 | EOI notification, one cycle after an effective EOI |
| eoi_vector | output | 8 | Vector retired by the EOI |
| eoi_level | output | 1 | 1 when the retired vector was level-triggered |

## Verification
The bench targets class-boundary cases. A pending vector whose class equals the processor priority class must stay hidden; a design that compared with greater-or-equal would deliver it too early. An in-service vector must raise `ppr` above a lower task priority; a design that ignored the in-service set would let lower-class requests preempt. The bench also covers a duplicate accept carrying a different trigger mode, an EOI and an acknowledge with nothing to act on, and an EOI issued in the same cycle as a re-accept of the retired vector. These catch a design that overwrites the trigger mode, emits a spurious notification, moves a vector that was not presented, or reports the new trigger mode in place of the old one. Random traffic over a small pool of vectors in different words checks the top-down search across word boundaries.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   // Width of a vector index for a given vector count.
   function automatic int unsigned idx_width(input int unsigned count);
      return (count <= 2) ? 1 : $clog2(count);
   endfunction

endpackage

// File: rtl/vpt_bitmap.sv
// One vector bitmap stored as NUM_VEC/WORD_W words with two write ports.
// Port A writes a value, port B clears; port A wins on the same bit.
module vpt_bitmap #(
   parameter int unsigned NUM_VEC = 256,
   parameter int unsigned WORD_W  = 32,
   localparam int unsigned VEC_W   = vpt_pkg::idx_width(NUM_VEC),
   localparam int unsigned BIT_W   = vpt_pkg::idx_width(WORD_W),
   localparam int unsigned NUM_WRD = NUM_VEC / WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wa_en,
   input  logic [VEC_W-1:0]   wa_idx,
   input  logic               wa_val,
   input  logic               wb_en,
   input  logic [VEC_W-1:0]   wb_idx,
   output logic [NUM_VEC-1:0] bits_o
);

   for (genvar w = 0; w < NUM_WRD; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      logic [WORD_W-1:0] word_d;
      logic              a_here;
      logic              b_here;
      logic [BIT_W-1:0]  a_bit;
      logic [BIT_W-1:0]  b_bit;

      assign a_here = wa_en && ((32'(wa_idx) >> BIT_W) == w);
      assign b_here = wb_en && ((32'(wb_idx) >> BIT_W) == w);
      assign a_bit  = wa_idx[BIT_W-1:0];
      assign b_bit  = wb_idx[BIT_W-1:0];

      always_comb begin
         word_d = word_q;
         if (b_here) word_d[b_bit] = 1'b0;
         if (a_here) word_d[a_bit] = wa_val;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) word_q <= '0;
         else        word_q <= word_d;
      end

      assign bits_o[w*WORD_W +: WORD_W] = word_q;
   end

   // R12
   wr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wa_en |=> (bits_o[$past(wa_idx)] == $past(wa_val)));

   // R9
   clr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && !(wa_en && wa_idx == wb_idx)) |=> !bits_o[$past(wb_idx)]);

endmodule

// File: rtl/vpt_top_finder.sv
// Highest set bit search: each word gets its own msb encoder, then the
// highest non-empty word wins. Purely combinational.
module vpt_top_finder #(
   parameter int unsigned NUM_VEC = 256,
   parameter int unsigned WORD_W  = 32,
   localparam int unsigned VEC_W   = vpt_pkg::idx_width(NUM_VEC),
   localparam int unsigned BIT_W   = vpt_pkg::idx_width(WORD_W),
   localparam int unsigned NUM_WRD = NUM_VEC / WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] bits_i,
   output logic               found,
   output logic [VEC_W-1:0]   idx
);

   function automatic logic [BIT_W-1:0] msb_of(input logic [WORD_W-1:0] x);
      logic [BIT_W-1:0] r;
      r = '0;
      for (int b = 0; b < int'(WORD_W); b++)
         if (x[b]) r = BIT_W'(b);
      return r;
   endfunction

   logic             word_any [NUM_WRD];
   logic [BIT_W-1:0] word_msb [NUM_WRD];

   for (genvar w = 0; w < NUM_WRD; w++) begin : g_enc
      assign word_any[w] = |bits_i[w*WORD_W +: WORD_W];
      assign word_msb[w] = msb_of(bits_i[w*WORD_W +: WORD_W]);
   end

   // Later (higher) words overwrite earlier ones: top word down priority.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int w = 0; w < int'(NUM_WRD); w++) begin
         if (word_any[w]) begin
            found = 1'b1;
            idx   = VEC_W'(w * int'(WORD_W)) | VEC_W'(word_msb[w]);
         end
      end
   end

   // R5
   hit_is_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> bits_i[idx]);

   // R5
   none_is_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !found |-> (bits_i == '0));

   // R5
   nothing_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> ((bits_i >> idx) == NUM_VEC'(1)));

endmodule

// File: rtl/vpt_prio_calc.sv
// Processor priority from task priority and the highest in-service vector.
module vpt_prio_calc #(
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned CLASS_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VEC_W-1:0] tpr,
   input  logic             isr_found,
   input  logic [VEC_W-1:0] isr_top,
   output logic [VEC_W-1:0] ppr
);

   localparam int unsigned SUB_W = VEC_W - CLASS_W;

   logic [VEC_W-1:0]   isr_eff;
   logic [CLASS_W-1:0] tpr_cls;
   logic [CLASS_W-1:0] isr_cls;

   assign isr_eff = isr_found ? isr_top : '0;
   assign tpr_cls = tpr[VEC_W-1 -: CLASS_W];
   assign isr_cls = isr_eff[VEC_W-1 -: CLASS_W];

   always_comb begin
      if (tpr_cls >= isr_cls) ppr = tpr;
      else                    ppr = {isr_cls, {SUB_W{1'b0}}};
   end

   // R6
   ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ppr >= tpr) && (ppr[VEC_W-1 -: CLASS_W] >= isr_cls));

endmodule

// File: rtl/vec_prio_tracker.sv
module vec_prio_tracker #(
   parameter int unsigned NUM_VEC  = 256,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned CLASS_W  = 4,
   parameter int unsigned TPR_IN_W = 32,
   localparam int unsigned VEC_W   = vpt_pkg::idx_width(NUM_VEC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctl_enable,
   input  logic                acc_valid,
   input  logic [VEC_W-1:0]    acc_vector,
   input  logic                acc_level,
   output logic                acc_taken,
   input  logic                tpr_wr,
   input  logic [TPR_IN_W-1:0] tpr_wdata,
   input  logic                ack,
   input  logic                eoi,
   output logic                irq_valid,
   output logic [VEC_W-1:0]    irq_vector,
   output logic [VEC_W-1:0]    ppr,
   output logic                eoi_valid,
   output logic [VEC_W-1:0]    eoi_vector,
   output logic                eoi_level
);
   import vpt_pkg::*;

   // Elaboration-time parameter checks.
   if ((1 << VEC_W) != NUM_VEC) begin : g_bad_count
      $error("NUM_VEC must be a power of two");
   end
   if (WORD_W < 2 || (NUM_VEC % WORD_W) != 0) begin : g_bad_word
      $error("WORD_W must be at least 2 and divide NUM_VEC");
   end
   if (CLASS_W == 0 || CLASS_W >= VEC_W) begin : g_bad_class
      $error("CLASS_W must be between 1 and VEC_W-1");
   end
   if (TPR_IN_W < VEC_W) begin : g_bad_tpr
      $error("TPR_IN_W must cover a vector");
   end

   logic [NUM_VEC-1:0] irr_bits;
   logic [NUM_VEC-1:0] isr_bits;
   logic [NUM_VEC-1:0] tmr_bits;
   logic               irr_found;
   logic [VEC_W-1:0]   irr_top;
   logic               isr_found;
   logic [VEC_W-1:0]   isr_top;
   logic [VEC_W-1:0]   tpr_q;
   logic               do_ack;
   logic               do_eoi;

   // Accept path
   assign acc_taken = acc_valid && ctl_enable && !irr_bits[acc_vector];

   // Delivery decision
   assign irq_valid  = irr_found &&
                       (irr_top[VEC_W-1 -: CLASS_W] > ppr[VEC_W-1 -: CLASS_W]);
   assign irq_vector = irr_top;
   assign do_ack     = ack && irq_valid;
   assign do_eoi     = eoi && isr_found;

   vpt_bitmap #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_irr (
      .clk(clk), .rst_n(rst_n),
      .wa_en(acc_taken), .wa_idx(acc_vector), .wa_val(1'b1),
      .wb_en(do_ack), .wb_idx(irr_top),
      .bits_o(irr_bits));

   vpt_bitmap #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isr (
      .clk(clk), .rst_n(rst_n),
      .wa_en(do_ack), .wa_idx(irr_top), .wa_val(1'b1),
      .wb_en(do_eoi), .wb_idx(isr_top),
      .bits_o(isr_bits));

   vpt_bitmap #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .wa_en(acc_taken), .wa_idx(acc_vector), .wa_val(acc_level),
      .wb_en(do_eoi), .wb_idx(isr_top),
      .bits_o(tmr_bits));

   vpt_top_finder #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_find_irr (
      .clk(clk), .rst_n(rst_n), .bits_i(irr_bits),
      .found(irr_found), .idx(irr_top));

   vpt_top_finder #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_find_isr (
      .clk(clk), .rst_n(rst_n), .bits_i(isr_bits),
      .found(isr_found), .idx(isr_top));

   vpt_prio_calc #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_prio (
      .clk(clk), .rst_n(rst_n), .tpr(tpr_q),
      .isr_found(isr_found), .isr_top(isr_top), .ppr(ppr));

   // Task priority register
   always_ff @(posedge clk) begin
      if (!rst_n)      tpr_q <= '0;
      else if (tpr_wr) tpr_q <= tpr_wdata[VEC_W-1:0];
   end

   // EOI notification, one cycle after the retiring strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eoi_valid  <= 1'b0;
         eoi_vector <= '0;
         eoi_level  <= 1'b0;
      end else begin
         eoi_valid <= do_eoi;
         if (do_eoi) begin
            eoi_vector <= isr_top;
            eoi_level  <= (tmr_bits[isr_top] == TRIG_LEVEL);
         end
      end
   end

   // R2
   accept_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_taken |=> irr_bits[$past(acc_vector)]);

   // R4
   disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_enable |=> ((irr_bits & ~$past(irr_bits)) == '0));

   // R7
   presented_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irr_bits[irq_vector] && !isr_bits[irq_vector]));

   // R8
   ack_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_ack |=> (isr_bits[$past(irq_vector)] && !irr_bits[$past(irq_vector)]));

   // R8
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack && !eoi) |=> $stable(isr_bits));

   // R9
   eoi_retired_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_valid |-> !isr_bits[eoi_vector]);

   // R10
   eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && (isr_bits == '0)) |=> !eoi_valid);

   // R11
   tpr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tpr_wr |=> (tpr_q == $past(tpr_wdata[VEC_W-1:0])));

endmodule

// File: tb/vec_prio_tracker_test.sv
`timescale 1ns/1ps
module vec_prio_tracker_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_enable = 1'b0;
   logic        acc_valid = 1'b0;
   logic [7:0]  acc_vector = '0;
   logic        acc_level = 1'b0;
   logic        acc_taken;
   logic        tpr_wr = 1'b0;
   logic [31:0] tpr_wdata = '0;
   logic        ack = 1'b0;
   logic        eoi = 1'b0;
   logic        irq_valid;
   logic [7:0]  irq_vector;
   logic [7:0]  ppr;
   logic        eoi_valid;
   logic [7:0]  eoi_vector;
   logic        eoi_level;

   always #10 clk = ~clk; // 50 MHz

   vec_prio_tracker uut (
      .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable),
      .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_level(acc_level),
      .acc_taken(acc_taken), .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
      .ack(ack), .eoi(eoi), .irq_valid(irq_valid), .irq_vector(irq_vector),
      .ppr(ppr), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .eoi_level(eoi_level));

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // Reference model state
   logic [255:0] m_irr = '0;
   logic [255:0] m_isr = '0;
   logic [255:0] m_tmr = '0;
   logic [7:0]   m_tpr = '0;
   bit           x_eoi_v = 0;
   logic [7:0]   x_eoi_vec = '0;
   bit           x_eoi_lvl = 0;
   bit           last_taken = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int hi(input logic [255:0] b);
      int r = -1;
      for (int i = 0; i < 256; i++) if (b[i]) r = i;
      return r;
   endfunction

   function automatic logic [7:0] ppr_of(input logic [7:0] t, input int isr_h);
      logic [7:0] v = (isr_h < 0) ? 8'h00 : 8'(isr_h);
      if (t[7:4] >= v[7:4]) return t;
      return {v[7:4], 4'h0};
   endfunction

   task automatic step(input bit en, input bit av, input logic [7:0] avec,
                       input bit alvl, input bit tw, input logic [31:0] td,
                       input bit ak, input bit eo);
      int         top, isr_h;
      logic [7:0] e_ppr;
      bit         e_irq, e_taken;
      logic [255:0] n_irr, n_isr, n_tmr;
      @(negedge clk);
      ctl_enable = en; acc_valid = av; acc_vector = avec; acc_level = alvl;
      tpr_wr = tw; tpr_wdata = td; ack = ak; eoi = eo;
      #1;
      top   = hi(m_irr);
      isr_h = hi(m_isr);
      e_ppr = ppr_of(m_tpr, isr_h);
      e_irq = (top >= 0) && (top[7:4] > int'(e_ppr[7:4]));
      e_taken = av && en && !m_irr[avec];
      chk(ppr == e_ppr, "R6 ppr", ppr, e_ppr);
      chk(irq_valid == e_irq, "R7 irq_valid", irq_valid, e_irq);
      if (e_irq) chk(irq_vector == 8'(top), "R5 irq_vector", irq_vector, top);
      chk(acc_taken == e_taken, "R2 acc_taken", acc_taken, e_taken);
      chk(eoi_valid == x_eoi_v, "R9 eoi_valid", eoi_valid, x_eoi_v);
      if (x_eoi_v) begin
         chk(eoi_vector == x_eoi_vec, "R9 eoi_vector", eoi_vector, x_eoi_vec);
         chk(eoi_level == x_eoi_lvl, "R9 eoi_level", eoi_level, x_eoi_lvl);
      end
      n_irr = m_irr; n_isr = m_isr; n_tmr = m_tmr;
      if (ak && e_irq) begin n_isr[top] = 1'b1; n_irr[top] = 1'b0; end
      if (eo && isr_h >= 0) begin
         n_isr[isr_h] = 1'b0; n_tmr[isr_h] = 1'b0;
         x_eoi_v = 1; x_eoi_vec = 8'(isr_h); x_eoi_lvl = m_tmr[isr_h];
      end else x_eoi_v = 0;
      if (e_taken) begin n_irr[avec] = 1'b1; n_tmr[avec] = alvl; end
      last_taken = e_taken;
      @(posedge clk);
      m_irr = n_irr; m_isr = n_isr; m_tmr = n_tmr;
      if (tw) m_tpr = td[7:0];
      #1;
   endtask

   task automatic idle();
      step(1, 0, 8'h00, 0, 0, 32'h0, 0, 0);
   endtask

   initial begin
      int unsigned seed_dummy;
      logic [7:0] pool [8];
      pool = '{8'h10, 8'h2F, 8'h31, 8'h45, 8'h7E, 8'h80, 8'hC3, 8'hFF};
      seed_dummy = $urandom(32'h5EED_1234);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; #1;
      chk(irq_valid == 0, "R1 irq_valid", irq_valid, 0);
      chk(ppr == 0, "R1 ppr", ppr, 0);
      chk(eoi_valid == 0, "R1 eoi_valid", eoi_valid, 0);

      // R4: disabled controller drops requests
      step(0, 1, 8'h30, 0, 0, 0, 0, 0);
      chk(last_taken == 0, "R4 taken", last_taken, 0);
      chk(irq_valid == 0, "R4 irq_valid", irq_valid, 0);
      // R2: accept level vector
      step(1, 1, 8'h45, 1, 0, 0, 0, 0);
      chk(last_taken == 1, "R2 taken", last_taken, 1);
      chk(irq_valid == 1 && irq_vector == 8'h45, "R2 presented", irq_vector, 8'h45);
      // R3: duplicate with edge mode is rejected
      step(1, 1, 8'h45, 0, 0, 0, 0, 0);
      chk(last_taken == 0, "R3 duplicate", last_taken, 0);
      // R5: highest across words
      step(1, 1, 8'hE0, 0, 0, 0, 0, 0);
      step(1, 1, 8'h21, 0, 0, 0, 0, 0);
      chk(irq_vector == 8'hE0, "R5 top word", irq_vector, 8'hE0);
      // R11: only low byte kept
      step(1, 0, 0, 0, 1, 32'hABCD_1234, 0, 0);
      chk(ppr == 8'h34, "R11 tpr low byte", ppr, 8'h34);
      // R6/R7 with in-service vector
      step(1, 0, 0, 0, 0, 0, 1, 0);
      chk(ppr == 8'hE0, "R6 isr raises ppr", ppr, 8'hE0);
      chk(irq_valid == 0, "R7 lower class held", irq_valid, 0);
      // R9 edge retire
      step(1, 0, 0, 0, 0, 0, 0, 1);
      chk(eoi_valid && eoi_vector == 8'hE0 && !eoi_level, "R9 edge eoi", eoi_vector, 8'hE0);
      chk(ppr == 8'h34, "R6 ppr back", ppr, 8'h34);
      step(1, 0, 0, 0, 0, 0, 1, 0);
      chk(ppr == 8'h40, "R6 ppr 0x40", ppr, 8'h40);
      chk(irq_valid == 0, "R7 class below", irq_valid, 0);
      step(1, 0, 0, 0, 0, 0, 0, 1);
      chk(eoi_valid && eoi_vector == 8'h45 && eoi_level, "R9 level eoi", eoi_level, 1);
      chk(irq_valid == 0, "R7 tpr gate", irq_valid, 0);
      // R10: eoi on empty set
      step(1, 0, 0, 0, 0, 0, 0, 1);
      chk(eoi_valid == 0, "R10 no notify", eoi_valid, 0);
      chk(ppr == 8'h34, "R10 ppr kept", ppr, 8'h34);
      // R8: ack with nothing presented
      step(1, 0, 0, 0, 0, 0, 1, 0);
      step(1, 0, 0, 0, 1, 32'h0, 0, 0);
      chk(irq_valid == 1 && irq_vector == 8'h21, "R8 pending kept", irq_vector, 8'h21);
      chk(ppr == 8'h00, "R8 isr untouched", ppr, 0);
      step(1, 0, 0, 0, 0, 0, 1, 0);
      step(1, 0, 0, 0, 0, 0, 0, 1);
      // R12: same-cycle eoi and re-accept of the retired vector
      step(1, 1, 8'h60, 1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0, 1, 0);
      step(1, 1, 8'h60, 0, 0, 0, 0, 1);
      chk(last_taken == 1, "R12 reaccept taken", last_taken, 1);
      chk(eoi_valid && eoi_level, "R12 old trigger reported", eoi_level, 1);
      step(1, 0, 0, 0, 0, 0, 1, 0);
      step(1, 0, 0, 0, 0, 0, 0, 1);
      chk(eoi_valid && !eoi_level, "R12 new trigger kept", eoi_level, 0);
      idle();

      // Constrained random phase
      for (int n = 0; n < 4000; n++) begin
         logic [7:0] v;
         int unsigned r = $urandom;
         v = (r[1:0] == 2'd0) ? 8'($urandom) : pool[$urandom % 8];
         step(($urandom % 16) != 0, ($urandom % 3) == 0, v, $urandom % 2,
              ($urandom % 20) == 0, $urandom, ($urandom % 3) == 0,
              ($urandom % 4) == 0);
      end
      idle();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule